// File: doc/BRIEF.md
# Circular-Buffer Address Generator

This block computes one data-memory address per cycle for a DSP datapath. An issued operation selects one of seven addressing forms. Three use only the instruction fields: an immediate, a register-file operand, or the two added. Two add the internal address pointer to the immediate or to the register operand. Two step the pointer, either after use (post-increment) or before use (pre-decrement). Every sum is taken modulo 2^AW.

The two stepping forms move the pointer by a programmable stride. When the circular option is on, the pointer stays inside a window that starts at a lower bound and ends just below an exclusive upper bound. A step that leaves the window is pulled back by the window length. This works for strides larger than one. Increments compare against the upper bound and decrements against the lower one.

A small write port loads the lower bound, the upper bound, the window length, the stride, the pointer and the circular-enable bit. The address and a memory enable are registered. The enable is low in every cycle without an access, so the memory can idle.

Top module: `modulo_agu`

## Requirements
- R1: After reset, mem_en is 0, mem_addr is 0, the pointer (ar_q) is 0, the stride is 1, the bounds and window length are 0, and circular mode is off.
- R2: A valid op with op_mode 0 gives op_imm, op_mode 2 gives op_reg, and op_mode 3 gives op_reg+op_imm, all modulo 2^AW. The address appears on mem_addr the cycle after issue, and the pointer does not change.
- R3: op_mode 1 gives ar_q+op_imm and op_mode 6 gives ar_q+op_reg, both modulo 2^AW, and the pointer does not change.
- R4: op_mode 4 (post-increment) outputs the current pointer, and the pointer moves forward by one stride on the same edge.
- R5: op_mode 5 (pre-decrement) moves the pointer back by one stride, and the moved value is the output address.
- R6: With circular mode off, forward steps give ar+stride and backward steps give ar-stride, both modulo 2^AW.
- R7: With circular mode on, a forward step for which (upper - ar) modulo 2^AW is at most the stride gives ar+stride-length. Any other forward step gives ar+stride. With stride 1 this reloads the lower bound when the upper bound is reached.
- R8: With circular mode on, a backward step for which (ar - lower) modulo 2^AW is below the stride gives ar-stride+length. Any other backward step gives ar-stride.
- R9: mem_en is 1 in exactly the cycle after a valid op with op_mode 0 to 6. Otherwise it is 0, including after op_mode 7 (no access). In those cycles mem_addr holds its last value and the pointer is unchanged.
- R10: A write with cfg_we=1 loads cfg_data into the target chosen by cfg_sel: 0 lower bound, 1 upper bound, 2 length, 3 stride, 4 pointer, 5 circular enable (bit 0). The new value takes effect from the next cycle, and an op in the same cycle uses the old settings. A pointer write overrides the same cycle's pointer step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Address operation issued this cycle |
| op_mode | input | 3 | Addressing form, codes 0 to 7 |
| op_imm | input | AW | Immediate operand |
| op_reg | input | AW | Register-file operand |
| cfg_we | input | 1 | Setting write strobe |
| cfg_sel | input | 3 | Setting target code |
| cfg_data | input | AW | Setting write value |
| mem_en | output | 1 | Memory access enable, registered |
| mem_addr | output | AW | Memory address, registered |
| ar_q | output | AW | Current address pointer |

## Verification
A wrong pointer value shows on ar_q at the edge that writes it. It also corrupts mem_addr on the next pointer-relative or stepping access, so a bad wrap correction shows within one cycle of the step that crosses a bound. A stuck or spurious enable shows on mem_en one cycle after the op that should have set or cleared it. A mis-routed setting write shows at the first step that depends on that setting. Random windows with strides up to the window length make sure that both bounds are crossed in both directions.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [2:0] {
    M_DIRECT   = 3'd0,
    M_AR_IMM   = 3'd1,
    M_REG      = 3'd2,
    M_REG_IMM  = 3'd3,
    M_POST_INC = 3'd4,
    M_PRE_DEC  = 3'd5,
    M_AR_REG   = 3'd6,
    M_IDLE     = 3'd7
  } agu_mode_e;

  typedef enum logic [2:0] {
    S_LOWER = 3'd0,
    S_UPPER = 3'd1,
    S_LEN   = 3'd2,
    S_STRIDE= 3'd3,
    S_PTR   = 3'd4,
    S_CIRC  = 3'd5
  } agu_sel_e;
endpackage

// File: rtl/agu_cfg_regs.sv
module agu_cfg_regs
  import agu_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [AW-1:0] cfg_data,
  output logic [AW-1:0] lower_q,
  output logic [AW-1:0] upper_q,
  output logic [AW-1:0] len_q,
  output logic [AW-1:0] stride_q,
  output logic          circ_q
);
  localparam logic [AW-1:0] STRIDE_RST = AW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lower_q  <= '0;
      upper_q  <= '0;
      len_q    <= '0;
      stride_q <= STRIDE_RST;
      circ_q   <= 1'b0;
    end else if (cfg_we) begin
      case (agu_sel_e'(cfg_sel))
        S_LOWER:  lower_q  <= cfg_data;
        S_UPPER:  upper_q  <= cfg_data;
        S_LEN:    len_q    <= cfg_data;
        S_STRIDE: stride_q <= cfg_data;
        S_CIRC:   circ_q   <= cfg_data[0];
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/agu_step_unit.sv
module agu_step_unit #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] ar,
  input  logic [AW-1:0] lower,
  input  logic [AW-1:0] upper,
  input  logic [AW-1:0] len,
  input  logic [AW-1:0] stride,
  input  logic          circ,
  output logic [AW-1:0] ar_fwd,
  output logic [AW-1:0] ar_back,
  output logic          fwd_wrap,
  output logic          back_wrap
);
  // Distance tests avoid overflow of ar+stride and ar-stride.
  function automatic logic crosses_upper(input logic [AW-1:0] p, input logic [AW-1:0] hi,
                                         input logic [AW-1:0] s);
    logic [AW-1:0] room;
    room = hi - p;
    return room <= s;
  endfunction

  function automatic logic crosses_lower(input logic [AW-1:0] p, input logic [AW-1:0] lo,
                                         input logic [AW-1:0] s);
    logic [AW-1:0] room;
    room = p - lo;
    return room < s;
  endfunction

  always_comb begin
    fwd_wrap  = circ && crosses_upper(ar, upper, stride);
    back_wrap = circ && crosses_lower(ar, lower, stride);
    ar_fwd    = fwd_wrap  ? (ar + stride - len) : (ar + stride);
    ar_back   = back_wrap ? (ar - stride + len) : (ar - stride);
  end
endmodule

// File: rtl/agu_addr_sel.sv
module agu_addr_sel
  import agu_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [2:0]    mode,
  input  logic [AW-1:0] imm,
  input  logic [AW-1:0] rf,
  input  logic [AW-1:0] ar,
  input  logic [AW-1:0] ar_fwd,
  input  logic [AW-1:0] ar_back,
  output logic [AW-1:0] addr,
  output logic          access,
  output logic          ptr_step,
  output logic [AW-1:0] ptr_next
);
  always_comb begin
    addr     = '0;
    access   = 1'b1;
    ptr_step = 1'b0;
    ptr_next = ar;
    case (agu_mode_e'(mode))
      M_DIRECT:   addr = imm;
      M_AR_IMM:   addr = ar + imm;
      M_REG:      addr = rf;
      M_REG_IMM:  addr = rf + imm;
      M_AR_REG:   addr = ar + rf;
      M_POST_INC: begin
        addr     = ar;
        ptr_step = 1'b1;
        ptr_next = ar_fwd;
      end
      M_PRE_DEC: begin
        addr     = ar_back;
        ptr_step = 1'b1;
        ptr_next = ar_back;
      end
      default:    access = 1'b0;
    endcase
  end
endmodule

// File: rtl/modulo_agu.sv
module modulo_agu
  import agu_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [2:0]    op_mode,
  input  logic [AW-1:0] op_imm,
  input  logic [AW-1:0] op_reg,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_sel,
  input  logic [AW-1:0] cfg_data,
  output logic          mem_en,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] ar_q
);
  logic [AW-1:0] lower_q, upper_q, len_q, stride_q;
  logic          circ_q;
  logic [AW-1:0] ar_fwd, ar_back, addr_c, ptr_next;
  logic          fwd_wrap, back_wrap, access_c, ptr_step;
  logic          fire, ptr_wr, ptr_move;

  agu_cfg_regs #(.AW(AW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .lower_q(lower_q), .upper_q(upper_q), .len_q(len_q), .stride_q(stride_q), .circ_q(circ_q)
  );

  agu_step_unit #(.AW(AW)) u_step (
    .ar(ar_q), .lower(lower_q), .upper(upper_q), .len(len_q), .stride(stride_q), .circ(circ_q),
    .ar_fwd(ar_fwd), .ar_back(ar_back), .fwd_wrap(fwd_wrap), .back_wrap(back_wrap)
  );

  agu_addr_sel #(.AW(AW)) u_sel (
    .mode(op_mode), .imm(op_imm), .rf(op_reg), .ar(ar_q), .ar_fwd(ar_fwd), .ar_back(ar_back),
    .addr(addr_c), .access(access_c), .ptr_step(ptr_step), .ptr_next(ptr_next)
  );

  // Named events for the checks below.
  assign fire     = op_valid && access_c;
  assign ptr_wr   = cfg_we && (cfg_sel == S_PTR);
  assign ptr_move = fire && ptr_step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ar_q <= '0;
    end else if (ptr_wr) begin
      ar_q <= cfg_data;
    end else if (ptr_move) begin
      ar_q <= ptr_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_en   <= 1'b0;
      mem_addr <= '0;
    end else begin
      mem_en <= fire;
      if (fire) mem_addr <= addr_c;
    end
  end

  p_en_on_access_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_mode != M_IDLE) |=> mem_en);

  p_en_off_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(op_valid && op_mode != M_IDLE) |=> (!mem_en && $stable(mem_addr)));

  p_ptr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we && !(op_valid && (op_mode == M_POST_INC || op_mode == M_PRE_DEC))) |=> $stable(ar_q));

  p_post_uses_old_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_mode == M_POST_INC) |=> (mem_addr == $past(ar_q)));

  p_pre_uses_new_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_mode == M_PRE_DEC && !ptr_wr) |=> (mem_addr == ar_q));

  p_stay_in_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_move && !cfg_we && circ_q && ar_q >= lower_q && ar_q < upper_q
     && len_q == upper_q - lower_q && stride_q <= len_q)
    |=> (ar_q >= $past(lower_q) && ar_q < $past(upper_q)));
endmodule

// File: tb/modulo_agu_test.sv
module modulo_agu_test;
  localparam int AW = 16;
  localparam int CLK_P = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          op_valid = 1'b0;
  logic [2:0]    op_mode = 3'd7;
  logic [AW-1:0] op_imm = '0, op_reg = '0;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_sel = '0;
  logic [AW-1:0] cfg_data = '0;
  logic          mem_en;
  logic [AW-1:0] mem_addr, ar_q;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  // Bench model of the visible state.
  logic [AW-1:0] m_lo = '0, m_hi = '0, m_len = '0, m_st = 16'd1, m_ar = '0, m_addr = '0;
  logic          m_circ = 1'b0, m_en = 1'b0;

  modulo_agu #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_mode(op_mode), .op_imm(op_imm),
    .op_reg(op_reg), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .mem_en(mem_en), .mem_addr(mem_addr), .ar_q(ar_q)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string req, input string what, input logic [AW-1:0] act,
                       input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Forward step, R6/R7: room to the upper bound decides the fold.
  function automatic logic [AW-1:0] go_fwd(input logic [AW-1:0] p);
    logic [AW-1:0] room;
    room = m_hi - p;
    if (m_circ && !(room > m_st)) return p + m_st - m_len;
    return p + m_st;
  endfunction

  // Backward step, R6/R8.
  function automatic logic [AW-1:0] go_back(input logic [AW-1:0] p);
    logic [AW-1:0] room;
    room = p - m_lo;
    if (m_circ && m_st > room) return p - m_st + m_len;
    return p - m_st;
  endfunction

  function automatic string req_of(input logic [2:0] md);
    case (md)
      3'd0, 3'd2, 3'd3: return "R2";
      3'd1, 3'd6:       return "R3";
      3'd4:             return m_circ ? "R7" : "R4";
      3'd5:             return m_circ ? "R8" : "R5";
      default:          return "R9";
    endcase
  endfunction

  // Starts just after a negedge; ends just after the next negedge.
  task automatic cycle(input logic v, input logic [2:0] md, input logic [AW-1:0] im,
                       input logic [AW-1:0] rg, input logic we, input logic [2:0] sl,
                       input logic [AW-1:0] dt, input string tag);
    logic [AW-1:0] n_ar;
    string rq;
    op_valid = v; op_mode = md; op_imm = im; op_reg = rg;
    cfg_we = we; cfg_sel = sl; cfg_data = dt;
    rq = (tag != "") ? tag : req_of(v ? md : 3'd7);
    n_ar = m_ar;
    m_en = v && (md != 3'd7);
    if (m_en) begin
      case (md)
        3'd0: m_addr = im;
        3'd1: m_addr = m_ar + im;
        3'd2: m_addr = rg;
        3'd3: m_addr = rg + im;
        3'd4: begin m_addr = m_ar; n_ar = go_fwd(m_ar); end
        3'd5: begin n_ar = go_back(m_ar); m_addr = n_ar; end
        default: m_addr = m_ar + rg;
      endcase
    end
    if (we) begin
      case (sl)
        3'd0: m_lo = dt;
        3'd1: m_hi = dt;
        3'd2: m_len = dt;
        3'd3: m_st = dt;
        3'd4: n_ar = dt;
        3'd5: m_circ = dt[0];
        default: ;
      endcase
    end
    m_ar = n_ar;
    @(posedge clk); #1;
    check(rq, "mem_en", {{(AW-1){1'b0}}, mem_en}, {{(AW-1){1'b0}}, m_en});
    check(rq, "mem_addr", mem_addr, m_addr);
    check(rq, "ar_q", ar_q, m_ar);
    @(negedge clk);
  endtask

  task automatic setw(input logic [2:0] sl, input logic [AW-1:0] dt);
    cycle(1'b0, 3'd7, '0, '0, 1'b1, sl, dt, "R10");
  endtask

  task automatic window(input logic [AW-1:0] lo, input logic [AW-1:0] len,
                        input logic [AW-1:0] st, input logic [AW-1:0] p);
    setw(3'd0, lo); setw(3'd1, lo + len); setw(3'd2, len);
    setw(3'd3, st); setw(3'd4, p); setw(3'd5, 16'd1);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=running expected=done");
      report();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0a61));
    #(CLK_P*2 + 2);
    // R1 reset values, sampled while still in reset.
    check("R1", "mem_en", {{(AW-1){1'b0}}, mem_en}, '0);
    check("R1", "mem_addr", mem_addr, '0);
    check("R1", "ar_q", ar_q, '0);
    @(negedge clk); rst_n = 1'b1;
    // R1 stride 1 and circular off: post-increment from 0 gives 1.
    cycle(1'b1, 3'd4, '0, '0, 1'b0, '0, '0, "R1");

    // R2/R3 direct forms and width wrap
    cycle(1'b1, 3'd0, 16'hBEEF, 16'h1234, 1'b0, '0, '0, "R2");
    cycle(1'b1, 3'd3, 16'hFFF0, 16'h0020, 1'b0, '0, '0, "R2");
    cycle(1'b1, 3'd6, '0, 16'hFFFF, 1'b0, '0, '0, "R3");

    // R6 linear wrap through 2^AW both ways
    setw(3'd3, 16'd2); setw(3'd4, 16'hFFFF);
    cycle(1'b1, 3'd4, '0, '0, 1'b0, '0, '0, "R6");
    cycle(1'b1, 3'd5, '0, '0, 1'b0, '0, '0, "R6");
    cycle(1'b1, 3'd5, '0, '0, 1'b0, '0, '0, "R6");

    // R7 unit stride reload of the lower bound; R8 reverse
    window(16'h0100, 16'd4, 16'd1, 16'h0103);
    cycle(1'b1, 3'd4, '0, '0, 1'b0, '0, '0, "R7");
    cycle(1'b1, 3'd5, '0, '0, 1'b0, '0, '0, "R8");
    // R7/R8 stride 3 in window of 8
    window(16'h0020, 16'd8, 16'd3, 16'h0026);
    cycle(1'b1, 3'd4, '0, '0, 1'b0, '0, '0, "R7");
    cycle(1'b1, 3'd5, '0, '0, 1'b0, '0, '0, "R8");
    cycle(1'b1, 3'd5, '0, '0, 1'b0, '0, '0, "R8");

    // R9 no-access cycles
    cycle(1'b1, 3'd7, 16'h5555, 16'h7777, 1'b0, '0, '0, "R9");
    cycle(1'b0, 3'd4, '0, '0, 1'b0, '0, '0, "R9");

    // R10 pointer write beats a same-cycle step; op uses old stride
    cycle(1'b1, 3'd4, '0, '0, 1'b1, 3'd4, 16'h0022, "R10");
    cycle(1'b1, 3'd4, '0, '0, 1'b1, 3'd3, 16'd5, "R10");
    cycle(1'b1, 3'd4, '0, '0, 1'b0, '0, '0, "R10");

    // Random windows, modes and occasional setting writes
    for (int blk = 0; blk < 40; blk++) begin
      logic [AW-1:0] len, lo;
      len = AW'(1 + ($urandom % 64));
      lo  = AW'($urandom);
      window(lo, len, AW'(1 + ($urandom % len)), lo + AW'($urandom % len));
      for (int k = 0; k < 60; k++) begin
        logic [2:0] md;
        logic we;
        md = 3'($urandom);
        we = ($urandom % 16) == 0;
        cycle(($urandom % 8) != 0, md, AW'($urandom), AW'($urandom),
              we, we ? 3'd3 : 3'd0, AW'(1 + ($urandom % len)), "");
      end
    end

    finished = 1'b1;
    report();
    $finish;
  end
endmodule